// File: doc/BRIEF.md
# Command Packet Header Parser

This block sits on a stream of 32-bit command words and works out what each one means. A word that arrives while the parser is waiting for a header is decoded as a packet header. The top header bits select one of five packet kinds: two older formats (register write and opcode), a one-word no-op, and two newer formats (register write and opcode). The newer formats protect their count field and their register or opcode field with odd parity bits. The parser then takes exactly as many payload words as the header announced.

Payload words of a register-write packet come out as write requests, with addresses that rise by one from the header's starting register. Opcode packets produce a start pulse that carries the opcode and the payload length, followed by each payload word on a data strobe. A header with a bad parity bit or an unknown type raises a one-cycle error pulse. That word is dropped, and the next word is taken as a fresh header.

Words are accepted on every clock where `in_valid` is high; the block never stalls its source. Every output is registered and appears one clock after the word that caused it.

Top module: `cmdp_parser`

## Requirements
- R1: While reset is applied, and in the cycles after it is released, all output strobes (`wr_valid`, `op_start`, `op_data_valid`, `err`) are low and the parser waits for a header.
- R2: A header with bits 31:30 = 2'b00 is an older register write. Its starting register is bits 14:0, zero-extended to 18 bits, and its payload count is the value in bits 29:16 plus one. The header itself produces no output strobe.
- R3: Payload word k (counting from 0) of a register-write packet produces `wr_valid` with `wr_addr` = start + k (modulo 2^18) and `wr_data` = the word.
- R4: A header with bits 31:30 = 2'b11 is an older opcode packet. The opcode is bits 15:8 and the count is bits 29:16 plus one. The header produces `op_start` with `op_code` and `op_count`. Each payload word then produces `op_data_valid` with `op_data` = the word.
- R5: A header with bits 31:30 = 2'b10 is a no-op. It occupies one word, ignores bits 29:0 and produces no output strobe.
- R6: A header with bits 31:28 = 4'h4 is a newer register write. The count is bits 6:0 with parity in bit 7, and the starting register is bits 25:8 with parity in bit 27. A count of 0 means the next word is again a header.
- R7: A header with bits 31:28 = 4'h7 is a newer opcode packet. The count is bits 14:0 with parity in bit 15, and the opcode is bits 22:16 with parity in bit 23. `op_code` is the opcode zero-extended to 8 bits. A count of 0 gives `op_start` with no payload.
- R8: Each parity bit of a newer header must be 1 exactly when its field has an even number of set bits. On any mismatch the header produces only an `err` pulse, and the next word is a header.
- R9: A header with bits 31:30 = 2'b01 whose bits 31:28 are neither 4'h4 nor 4'h7 produces only an `err` pulse, and the next word is a header.
- R10: In a cycle with `in_valid` low nothing is consumed and, one clock later, no strobe is raised. A payload may be interrupted by such cycles at any point.
- R11: Once the announced number of payload words has been consumed, the next word is decoded as a header. A payload word is never decoded as a header, whatever its top bits hold.
- R12: The outputs caused by a word accepted at a clock edge are visible after that edge and last one cycle; at most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A command word is presented this cycle |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register-write request strobe |
| wr_addr | output | 18 | Register address of the write |
| wr_data | output | 32 | Data of the write |
| op_start | output | 1 | Opcode packet header accepted |
| op_code | output | 8 | Opcode of the packet |
| op_count | output | 15 | Payload length of the opcode packet |
| op_data_valid | output | 1 | Opcode payload word strobe |
| op_data | output | 32 | Opcode payload word |
| err | output | 1 | Malformed header pulse |

## Verification
The bench targets the corner cases where a counting or decoding slip would shift the whole stream out of step. These include the largest older count (16384, which needs all 15 count bits), a newer register write of 127 words, and zero-count newer headers. If the parser consumed one word too many or too few, it would read a payload word as a header, or a header as data, and every later check would go wrong. Register addresses are driven across the 15-bit and 18-bit boundaries, which catches a narrow or non-wrapping address counter. Each of the four parity bits is corrupted in turn, and unknown type nibbles are sent; a parser that checked the wrong polarity or skipped a field would either accept a bad header or reject good ones. Idle gaps inside payloads and payload words that look like headers catch a design that advances without `in_valid` or decodes data as a header.

// File: rtl/cmdp_pkg.sv
`timescale 1ns/1ps
package cmdp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 15;
  localparam int unsigned ADDR_W = 18;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned PAR_W  = 18;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_REG = 2'd1,
    PH_OP  = 2'd2
  } phase_e;

  typedef struct packed {
    logic              is_reg;
    logic              is_op;
    logic              bad;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] base;
    logic [OP_W-1:0]   opc;
  } hdr_info_t;

  // Odd parity: the check bit must be set when the field has an even number of ones.
  function automatic logic par_ok(input logic [PAR_W-1:0] field, input logic pbit);
    return pbit == ~^field;
  endfunction
endpackage

// File: rtl/cmdp_hdr_dec.sv
`timescale 1ns/1ps
module cmdp_hdr_dec
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_info_t         info
);
  logic par_fail;

  always_comb begin
    info     = '0;
    par_fail = 1'b0;
    unique case (word[31:30])
      2'b00: begin
        info.is_reg = 1'b1;
        info.cnt    = CNT_W'(word[29:16]) + CNT_W'(1);
        info.base   = ADDR_W'(word[14:0]);
      end
      2'b10: begin
        info = '0;
      end
      2'b11: begin
        info.is_op = 1'b1;
        info.cnt   = CNT_W'(word[29:16]) + CNT_W'(1);
        info.opc   = word[15:8];
      end
      default: begin
        if (word[29:28] == 2'b00) begin
          info.is_reg = 1'b1;
          info.cnt    = CNT_W'(word[6:0]);
          info.base   = word[25:8];
          par_fail    = !(par_ok(PAR_W'(word[6:0]), word[7]) &&
                          par_ok(word[25:8], word[27]));
        end else if (word[29:28] == 2'b11) begin
          info.is_op = 1'b1;
          info.cnt   = word[14:0];
          info.opc   = OP_W'(word[22:16]);
          par_fail   = !(par_ok(PAR_W'(word[14:0]), word[15]) &&
                         par_ok(PAR_W'(word[22:16]), word[23]));
        end else begin
          par_fail = 1'b1;
        end
      end
    endcase
    if (par_fail) begin
      info.bad    = 1'b1;
      info.is_reg = 1'b0;
      info.is_op  = 1'b0;
    end
  end
endmodule

// File: rtl/cmdp_seq.sv
`timescale 1ns/1ps
module cmdp_seq
  import cmdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  hdr_info_t         info,
  output logic              hdr_phase,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              op_start,
  output logic [OP_W-1:0]   op_code,
  output logic [CNT_W-1:0]  op_count,
  output logic              op_data_valid,
  output logic [WORD_W-1:0] data_out,
  output logic              err
);
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_d, start_d, dv_d, err_d;
  logic [ADDR_W-1:0] waddr_d;
  logic [OP_W-1:0]   code_d;
  logic [CNT_W-1:0]  ocnt_d;
  logic [WORD_W-1:0] data_d;
  logic              hdr_take, pay_take;

  assign hdr_take  = in_valid && (phase_q == PH_HDR);
  assign pay_take  = in_valid && (phase_q != PH_HDR);
  assign hdr_phase = (phase_q == PH_HDR);

  always_comb begin
    phase_d = phase_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    wr_d    = 1'b0;
    start_d = 1'b0;
    dv_d    = 1'b0;
    err_d   = 1'b0;
    waddr_d = wr_addr;
    code_d  = op_code;
    ocnt_d  = op_count;
    data_d  = data_out;
    if (hdr_take) begin
      if (info.bad) begin
        err_d = 1'b1;
      end else if (info.is_reg) begin
        addr_d = info.base;
        rem_d  = info.cnt;
        if (info.cnt != '0) phase_d = PH_REG;
      end else if (info.is_op) begin
        start_d = 1'b1;
        code_d  = info.opc;
        ocnt_d  = info.cnt;
        rem_d   = info.cnt;
        if (info.cnt != '0) phase_d = PH_OP;
      end
    end
    if (pay_take) begin
      data_d = in_word;
      if (phase_q == PH_REG) begin
        wr_d    = 1'b1;
        waddr_d = addr_q;
        addr_d  = addr_q + ADDR_W'(1);
      end else begin
        dv_d = 1'b1;
      end
      rem_d = rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) phase_d = PH_HDR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= PH_HDR;
      rem_q         <= '0;
      addr_q        <= '0;
      wr_valid      <= 1'b0;
      wr_addr       <= '0;
      op_start      <= 1'b0;
      op_code       <= '0;
      op_count      <= '0;
      op_data_valid <= 1'b0;
      data_out      <= '0;
      err           <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      rem_q         <= rem_d;
      addr_q        <= addr_d;
      wr_valid      <= wr_d;
      wr_addr       <= waddr_d;
      op_start      <= start_d;
      op_code       <= code_d;
      op_count      <= ocnt_d;
      op_data_valid <= dv_d;
      data_out      <= data_d;
      err           <= err_d;
    end
  end
endmodule

// File: rtl/cmdp_parser.sv
`timescale 1ns/1ps
module cmdp_parser
  import cmdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              op_start,
  output logic [OP_W-1:0]   op_code,
  output logic [CNT_W-1:0]  op_count,
  output logic              op_data_valid,
  output logic [WORD_W-1:0] op_data,
  output logic              err
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  hdr_info_t         info;
  logic              hdr_phase;
  logic [WORD_W-1:0] data_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cmdp_hdr_dec u_dec (
    .word (in_word),
    .info (info)
  );

  cmdp_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .in_valid      (in_valid),
    .in_word       (in_word),
    .info          (info),
    .hdr_phase     (hdr_phase),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .op_start      (op_start),
    .op_code       (op_code),
    .op_count      (op_count),
    .op_data_valid (op_data_valid),
    .data_out      (data_out),
    .err           (err)
  );

  assign wr_data = data_out;
  assign op_data = data_out;
endmodule

// File: rtl/cmdp_parser_chk.sv
`timescale 1ns/1ps
module cmdp_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  hdr_top,
  input logic [25:0] hdr_low,
  input logic        hdr_phase,
  input logic        wr_valid,
  input logic [17:0] wr_addr,
  input logic        op_start,
  input logic        op_data_valid,
  input logic        err
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, op_start, op_data_valid, err})); // R12

  AST_NO_WORD_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || op_start || op_data_valid || err) |-> $past(in_valid)); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> (wr_addr == $past(wr_addr) + 18'd1)); // R3

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_phase && hdr_top[4:3] == 2'b10)
      |=> !(wr_valid || op_start || op_data_valid || err)); // R5

  AST_BAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_phase && hdr_top[4:3] == 2'b01 &&
     (hdr_top[2:1] == 2'b01 || hdr_top[2:1] == 2'b10)) |=> err); // R9

  AST_OP_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_phase && hdr_top[4:1] == 4'h7 &&
     ((hdr_low[15] == ^hdr_low[14:0]) || (hdr_low[23] == ^hdr_low[22:16]))) |=> err); // R8

  AST_REG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_phase && hdr_top[4:1] == 4'h4 &&
     ((hdr_low[7] == ^hdr_low[6:0]) || (hdr_top[0] == ^hdr_low[25:8]))) |=> err); // R8
endmodule

bind cmdp_parser cmdp_parser_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .in_valid      (in_valid),
  .hdr_top       (in_word[31:27]),
  .hdr_low       (in_word[25:0]),
  .hdr_phase     (hdr_phase),
  .wr_valid      (wr_valid),
  .wr_addr       (wr_addr),
  .op_start      (op_start),
  .op_data_valid (op_data_valid),
  .err           (err)
);

// File: tb/sim_cmdp_parser.sv
`timescale 1ns/1ps
module sim_cmdp_parser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        wr_valid, op_start, op_data_valid, err;
  logic [17:0] wr_addr;
  logic [31:0] wr_data, op_data;
  logic [7:0]  op_code;
  logic [14:0] op_count;

  int checks = 0;
  int fails  = 0;
  int m_phase = 0;
  int m_rem   = 0;
  logic [17:0] m_addr = '0;

  always #2.5 clk = ~clk;

  cmdp_parser u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_start(op_start), .op_code(op_code), .op_count(op_count),
    .op_data_valid(op_data_valid), .op_data(op_data), .err(err)
  );

  function automatic logic podd(input logic [31:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  function automatic logic [108:0] pack_out();
    return {wr_valid, wr_valid ? wr_addr : 18'h0, wr_valid ? wr_data : 32'h0,
            op_start, op_start ? op_code : 8'h0, op_start ? op_count : 15'h0,
            op_data_valid, op_data_valid ? op_data : 32'h0, err};
  endfunction

  function automatic logic [31:0] old_reg(input int idx, input int cnt);
    return {2'b00, 14'(cnt - 1), 1'b0, 15'(idx)};
  endfunction
  function automatic logic [31:0] old_op(input int op, input int cnt);
    return {2'b11, 14'(cnt - 1), 8'(op), 8'h00};
  endfunction
  function automatic logic [31:0] new_reg(input int off, input int cnt);
    logic [17:0] o = 18'(off);
    logic [6:0]  c = 7'(cnt);
    return {4'h4, podd({14'h0, o}), 1'b0, o, podd({25'h0, c}), c};
  endfunction
  function automatic logic [31:0] new_op(input int op, input int cnt);
    logic [6:0]  p = 7'(op);
    logic [14:0] c = 15'(cnt);
    return {4'h7, 4'h0, podd({25'h0, p}), p, podd({17'h0, c}), c};
  endfunction

  task automatic check(input string tag, input logic [108:0] exp);
    logic [108:0] act = pack_out();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, output logic [108:0] e, output string tag);
    logic ew = 0, es = 0, ed = 0, ee = 0;
    logic [17:0] ea = '0;
    logic [31:0] wd = '0, od = '0;
    logic [7:0]  eop = '0;
    logic [14:0] ec = '0;
    int cnt;
    tag = "R2";
    if (m_phase != 0) begin
      if (m_phase == 1) begin
        ew = 1; ea = m_addr; wd = w; m_addr = m_addr + 18'd1; tag = "R3";
      end else begin
        ed = 1; od = w; tag = "R4";
      end
      m_rem--;
      if (m_rem == 0) m_phase = 0;
    end else begin
      case (w[31:30])
        2'b00: begin
          cnt = int'(w[29:16]) + 1; m_addr = {3'b0, w[14:0]};
          m_rem = cnt; m_phase = 1; tag = "R2";
        end
        2'b10: tag = "R5";
        2'b11: begin
          cnt = int'(w[29:16]) + 1; es = 1; eop = w[15:8]; ec = 15'(cnt);
          m_rem = cnt; m_phase = 2; tag = "R4";
        end
        default: begin
          if (w[31:28] == 4'h4) begin
            if (w[7] != podd({25'h0, w[6:0]}) || w[27] != podd({14'h0, w[25:8]})) begin
              ee = 1; tag = "R8";
            end else begin
              tag = "R6"; cnt = int'(w[6:0]);
              if (cnt > 0) begin m_addr = w[25:8]; m_rem = cnt; m_phase = 1; end
            end
          end else if (w[31:28] == 4'h7) begin
            if (w[15] != podd({17'h0, w[14:0]}) || w[23] != podd({25'h0, w[22:16]})) begin
              ee = 1; tag = "R8";
            end else begin
              tag = "R7"; cnt = int'(w[14:0]);
              es = 1; eop = {1'b0, w[22:16]}; ec = w[14:0];
              if (cnt > 0) begin m_rem = cnt; m_phase = 2; end
            end
          end else begin
            ee = 1; tag = "R9";
          end
        end
      endcase
    end
    e = {ew, ea, wd, es, eop, ec, ed, od, ee};
  endtask

  // Caller stands at a falling edge; outputs are checked one clock later (R12).
  task automatic send(input logic [31:0] w, input string t = "");
    logic [108:0] e;
    string tag;
    model(w, e, tag);
    if (t != "") tag = t;
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_word  = $urandom();
    @(negedge clk);
    check("R10", '0);
  endtask

  task automatic payload(input int n);
    for (int i = 0; i < n; i++) send($urandom());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", '0);

    // Older register write, plain and across the 15-bit index boundary
    send(old_reg(16, 3)); payload(3);
    send(old_reg(15'h7FFE, 4)); payload(4);
    // Newer register write wrapping the 18-bit address
    send(new_reg(18'h3FFFE, 3)); payload(3);
    // Zero-count newer headers followed directly by headers
    send(new_reg(5, 0), "R6");
    send(new_op(9, 0), "R7");
    send(old_op(8'hA5, 2)); payload(2);
    // Largest newer register write
    send(new_reg(18'h01000, 127)); payload(127);
    send(new_op(7'h7F, 3)); payload(3);
    // No-op with arbitrary low bits, and header-like payload words
    send(32'hBFFF_FFFF, "R5");
    send(old_reg(5, 2));
    send(32'hC000_0000, "R11");
    send(new_op(3, 1), "R11");
    send(32'h8000_0000, "R11");
    // Each parity bit corrupted, each followed by a good header
    send(new_reg(18'h00123, 2) ^ 32'h0000_0080, "R8"); send(old_op(1, 1)); payload(1);
    send(new_reg(18'h00123, 2) ^ 32'h0800_0000, "R8"); send(new_reg(18'h00040, 1)); payload(1);
    send(new_op(7'h22, 4) ^ 32'h0000_8000, "R8"); send(32'h8000_0001);
    send(new_op(7'h22, 4) ^ 32'h0080_0000, "R8"); send(new_op(7'h22, 1)); payload(1);
    // Unknown type nibbles
    send(32'h5000_0000, "R9"); send(32'h6ABC_DEF0, "R9"); send(old_reg(1, 1)); payload(1);
    // Idle gaps inside a payload
    send(old_op(8'h11, 3)); send($urandom()); idle(); send($urandom());
    idle(); idle(); send($urandom()); idle();
    // Largest older counts (all count bits in use)
    send(old_reg(15'h7FFF, 16384)); payload(16384);
    send(old_op(8'h3C, 16384)); payload(16384);
    send(new_op(7'h01, 0), "R11");

    // Random mix
    for (int p = 0; p < 400; p++) begin
      int kind = int'($urandom_range(0, 6));
      int n;
      case (kind)
        0: begin n = int'($urandom_range(1, 6)); send(old_reg(int'($urandom()), n)); end
        1: begin n = int'($urandom_range(1, 6)); send(old_op(int'($urandom()), n)); end
        2: begin n = 0; send(32'h8000_0000 | (32'($urandom()) & 32'h3FFF_FFFF)); end
        3: begin n = int'($urandom_range(0, 6)); send(new_reg(int'($urandom()), n)); end
        4: begin n = int'($urandom_range(0, 6)); send(new_op(int'($urandom()), n)); end
        5: begin
          n = 0;
          case ($urandom_range(0, 3))
            0: send(new_reg(int'($urandom()), 3) ^ 32'h0000_0080, "R8");
            1: send(new_reg(int'($urandom()), 3) ^ 32'h0800_0000, "R8");
            2: send(new_op(int'($urandom()), 3) ^ 32'h0000_8000, "R8");
            default: send(new_op(int'($urandom()), 3) ^ 32'h0080_0000, "R8");
          endcase
        end
        default: begin
          n = 0;
          send({2'b01, ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10, 28'($urandom())}, "R9");
        end
      endcase
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 7) == 0) idle();
        send($urandom());
      end
    end
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule